// File: doc/BRIEF.md
# Per-Sequencer Conversion Result Queue

This block sits between the conversion engine of a multi-sequencer analog-to-digital converter and the processor. Each of the sequencers owns a private 16-deep queue of 32-bit results. The conversion side pushes a result together with the index of the sequencer that produced it. The processor pops from a queue by naming a sequencer index, and the popped word is available in the same cycle as the request.

Each queue keeps its read pointer, write pointer and empty and full flags in one packed status word. Software can read the word for any sequencer through a select input. A pop from an empty queue is not stalled. It returns zero and sets a sticky underflow bit for that sequencer. A push into a full queue is discarded and sets a sticky overflow bit. Both sticky registers are cleared by writing ones to the bits to be cleared.

Top module: `seq_result_fifo`

## Requirements
- R1: After a synchronous reset, every queue reports read pointer 0, write pointer 0, empty set and full clear, and both sticky registers read zero.
- R2: The status word for the selected sequencer has the following layout: read pointer in bits 3:0, write pointer in bits 7:4, empty in bit 8, full in bit 12. Bits 11:9 are zero.
- R3: A push to a queue that is not full stores the data at the write pointer, advances that pointer modulo 16 and clears empty. Full is set when the new write pointer equals the read pointer.
- R4: A push to a full queue is dropped. It leaves the queue's pointers and contents unchanged and sets bit n of the overflow register, where n is the push index.
- R5: A pop from a queue that is not empty returns the entry at the read pointer combinationally in the same cycle. The read pointer then advances modulo 16 and full is cleared. Empty is set when the new read pointer equals the write pointer.
- R6: A pop from an empty queue returns zero, moves no pointer and sets bit n of the underflow register, where n is the pop index.
- R7: Underflow and overflow bits are sticky. When the clear strobe is high, each bit at a one in its mask is cleared. A bit that is set in the same cycle as it is cleared ends up set.
- R8: The queues are independent. A push or pop on one sequencer changes no other sequencer's status, contents or sticky bits.
- R9: When a push and a pop name the same sequencer in one cycle, each one is judged on the flags that held before the cycle. If both succeed, the flags stay unchanged and both pointers advance.
- R10: Pointers wrap from 15 to 0, and data order is preserved across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push request from the conversion side |
| push_seq | input | 2 | Sequencer index of the push |
| push_data | input | 32 | Result word to store |
| pop_valid | input | 1 | Pop request from the processor side |
| pop_seq | input | 2 | Sequencer index of the pop |
| pop_data | output | 32 | Word at the read pointer, or zero if the queue is empty |
| status_seq | input | 2 | Selects which sequencer's status word is shown |
| status_word | output | 13 | Packed pointers and flags of the selected queue |
| clr_valid | input | 1 | Strobe for the write-one-to-clear masks |
| clr_under_mask | input | 4 | Underflow bits to clear |
| clr_over_mask | input | 4 | Overflow bits to clear |
| underflow_flags | output | 4 | Sticky underflow bits, one per sequencer |
| overflow_flags | output | 4 | Sticky overflow bits, one per sequencer |

## Verification
A push and a pop can land on the same sequencer in the same cycle. This is the case where the two update paths contend for the same flags. The bench provokes it on an empty queue, a full queue and a partly filled queue. It also hits the case many times during a long random mix in which both indices are drawn from all four sequencers. Every cycle, each queue's status word, the sticky registers and the popped word are compared with a model. The model decides push and pop acceptance from the flags that held before the edge, so an empty queue that sees both operations must show an underflow while still accepting the push, and a full queue must show an overflow while still completing the pop. A sticky bit that is set and cleared in the same cycle is also driven and must read back as set.

// File: rtl/seq_fifo_pkg.sv
package seq_fifo_pkg;
  localparam int unsigned FLAG_GAP = 3;

  function automatic int unsigned stat_width(input int unsigned ptr_w);
    return 2 * ptr_w + FLAG_GAP + 2;
  endfunction
endpackage

// File: rtl/seq_fifo_lane.sv
module seq_fifo_lane #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_en,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_en,
  output logic [DATA_W-1:0] pop_data,
  output logic [PTR_W-1:0]  head,
  output logic [PTR_W-1:0]  tail,
  output logic              empty,
  output logic              full,
  output logic              push_drop,
  output logic              pop_miss
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic push_ok, pop_ok;
  logic [PTR_W-1:0] head_nx, tail_nx;

  assign push_ok   = push_en && !full;
  assign pop_ok    = pop_en && !empty;
  assign push_drop = push_en && full;
  assign pop_miss  = pop_en && empty;
  assign head_nx   = head + 1'b1;
  assign tail_nx   = tail + 1'b1;
  assign pop_data  = empty ? '0 : mem[tail];

  always_ff @(posedge clk) begin
    if (push_ok) mem[head] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      empty <= 1'b1;
      full  <= 1'b0;
    end else begin
      if (push_ok) head <= head_nx;
      if (pop_ok)  tail <= tail_nx;
      if (push_ok && !pop_ok) begin
        empty <= 1'b0;
        full  <= (head_nx == tail);
      end else if (pop_ok && !push_ok) begin
        full  <= 1'b0;
        empty <= (tail_nx == head);
      end
    end
  end
endmodule

// File: rtl/seq_sticky_flags.sv
module seq_sticky_flags #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] flags
);
  logic [W-1:0] keep;
  assign keep = clr_en ? ~clr_mask : '1;

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & keep) | set_vec;
  end
endmodule

// File: rtl/seq_result_fifo.sv
module seq_result_fifo #(
  parameter int unsigned NUM_SEQ = 4,
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned SEQ_W  = $clog2(NUM_SEQ),
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned STAT_W = seq_fifo_pkg::stat_width(PTR_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push_valid,
  input  logic [SEQ_W-1:0]   push_seq,
  input  logic [DATA_W-1:0]  push_data,
  input  logic               pop_valid,
  input  logic [SEQ_W-1:0]   pop_seq,
  output logic [DATA_W-1:0]  pop_data,
  input  logic [SEQ_W-1:0]   status_seq,
  output logic [STAT_W-1:0]  status_word,
  input  logic               clr_valid,
  input  logic [NUM_SEQ-1:0] clr_under_mask,
  input  logic [NUM_SEQ-1:0] clr_over_mask,
  output logic [NUM_SEQ-1:0] underflow_flags,
  output logic [NUM_SEQ-1:0] overflow_flags
);
  localparam int unsigned EMPTY_POS = 2 * PTR_W;
  localparam int unsigned FULL_POS  = EMPTY_POS + seq_fifo_pkg::FLAG_GAP + 1;

  logic [NUM_SEQ-1:0]              lane_empty, lane_full;
  logic [NUM_SEQ-1:0]              lane_drop, lane_miss;
  logic [NUM_SEQ-1:0][PTR_W-1:0]   lane_head, lane_tail;
  logic [NUM_SEQ-1:0][DATA_W-1:0]  lane_rdata;

  for (genvar i = 0; i < NUM_SEQ; i++) begin : g_lane
    seq_fifo_lane #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .push_en   (push_valid && (push_seq == SEQ_W'(i))),
      .push_data (push_data),
      .pop_en    (pop_valid && (pop_seq == SEQ_W'(i))),
      .pop_data  (lane_rdata[i]),
      .head      (lane_head[i]),
      .tail      (lane_tail[i]),
      .empty     (lane_empty[i]),
      .full      (lane_full[i]),
      .push_drop (lane_drop[i]),
      .pop_miss  (lane_miss[i])
    );
  end

  assign pop_data = lane_rdata[pop_seq];

  always_comb begin
    status_word = '0;
    status_word[PTR_W-1:0]         = lane_tail[status_seq];
    status_word[2*PTR_W-1:PTR_W]   = lane_head[status_seq];
    status_word[EMPTY_POS]         = lane_empty[status_seq];
    status_word[FULL_POS]          = lane_full[status_seq];
  end

  seq_sticky_flags #(.W(NUM_SEQ)) u_under (
    .clk(clk), .rst(rst), .set_vec(lane_miss), .clr_en(clr_valid),
    .clr_mask(clr_under_mask), .flags(underflow_flags)
  );

  seq_sticky_flags #(.W(NUM_SEQ)) u_over (
    .clk(clk), .rst(rst), .set_vec(lane_drop), .clr_en(clr_valid),
    .clr_mask(clr_over_mask), .flags(overflow_flags)
  );
endmodule

// File: rtl/seq_result_fifo_chk.sv
module seq_result_fifo_chk #(
  parameter int unsigned NUM_SEQ = 4,
  parameter int unsigned PTR_W   = 4,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned SEQ_W  = $clog2(NUM_SEQ)
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          push_valid,
  input logic [SEQ_W-1:0]              push_seq,
  input logic                          pop_valid,
  input logic [SEQ_W-1:0]              pop_seq,
  input logic [DATA_W-1:0]             pop_data,
  input logic                          clr_valid,
  input logic [NUM_SEQ-1:0]            underflow_flags,
  input logic [NUM_SEQ-1:0]            overflow_flags,
  input logic [NUM_SEQ-1:0]            lane_empty,
  input logic [NUM_SEQ-1:0]            lane_full,
  input logic [NUM_SEQ-1:0][PTR_W-1:0] lane_head,
  input logic [NUM_SEQ-1:0][PTR_W-1:0] lane_tail
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q === 1'b1 && rst === 1'b0) begin
      assert_reset_state_R1: assert (lane_empty == '1 && lane_full == '0 &&
        underflow_flags == '0 && overflow_flags == '0);
    end
  end

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    (lane_empty & lane_full) == '0);

  assert_empty_pop_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (pop_valid && lane_empty[pop_seq]) |-> (pop_data == '0));

  assert_empty_pop_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (pop_valid && lane_empty[pop_seq]) |=> underflow_flags[$past(pop_seq)]);

  assert_full_push_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (push_valid && lane_full[push_seq]) |=> overflow_flags[$past(push_seq)]);

  assert_full_push_head_R4: assert property (@(posedge clk) disable iff (rst)
    (push_valid && lane_full[push_seq]) |=>
      (lane_head[$past(push_seq)] == $past(lane_head[push_seq])));

  assert_under_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !clr_valid |=> ((underflow_flags & $past(underflow_flags)) == $past(underflow_flags)));

  assert_over_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !clr_valid |=> ((overflow_flags & $past(overflow_flags)) == $past(overflow_flags)));
endmodule

bind seq_result_fifo seq_result_fifo_chk #(
  .NUM_SEQ(NUM_SEQ), .PTR_W(PTR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .push_valid(push_valid), .push_seq(push_seq),
  .pop_valid(pop_valid), .pop_seq(pop_seq), .pop_data(pop_data),
  .clr_valid(clr_valid), .underflow_flags(underflow_flags),
  .overflow_flags(overflow_flags), .lane_empty(lane_empty),
  .lane_full(lane_full), .lane_head(lane_head), .lane_tail(lane_tail)
);

// File: tb/seq_result_fifo_tb.sv
module seq_result_fifo_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst;
  logic        push_valid, pop_valid, clr_valid;
  logic [1:0]  push_seq, pop_seq, status_seq;
  logic [31:0] push_data, pop_data;
  logic [12:0] status_word;
  logic [3:0]  clr_under_mask, clr_over_mask, underflow_flags, overflow_flags;

  seq_result_fifo u_dut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_seq(push_seq),
    .push_data(push_data), .pop_valid(pop_valid), .pop_seq(pop_seq),
    .pop_data(pop_data), .status_seq(status_seq), .status_word(status_word),
    .clr_valid(clr_valid), .clr_under_mask(clr_under_mask),
    .clr_over_mask(clr_over_mask), .underflow_flags(underflow_flags),
    .overflow_flags(overflow_flags)
  );

  int n_tests = 0, n_fail = 0;
  logic [31:0] m_mem [4][16];
  int m_head [4], m_tail [4];
  bit m_empty [4], m_full [4];
  logic [3:0] m_uf, m_of;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int s = 0; s < 4; s++) begin
      logic [12:0] e;
      status_seq = 2'(s);
      #1;
      e = {m_full[s], 3'b000, m_empty[s], 4'(m_head[s]), 4'(m_tail[s])};
      check($sformatf("R2 %s status lane %0d", tag, s), 32'(status_word), 32'(e));
    end
    check({tag, " underflow"}, 32'(underflow_flags), 32'(m_uf));
    check({tag, " overflow"}, 32'(overflow_flags), 32'(m_of));
  endtask

  task automatic cyc(input bit pv, input int ps, input logic [31:0] pd,
                     input bit qv, input int qs, input bit cv,
                     input logic [3:0] cu, input logic [3:0] co, input string tag);
    logic [31:0] exp_pop;
    bit pu_ok, po_ok;
    @(negedge clk);
    push_valid = pv; push_seq = 2'(ps); push_data = pd;
    pop_valid = qv; pop_seq = 2'(qs);
    clr_valid = cv; clr_under_mask = cu; clr_over_mask = co;
    #1;
    exp_pop = m_empty[qs] ? 32'h0 : m_mem[qs][m_tail[qs]];
    if (qv) check({tag, " pop data"}, pop_data, exp_pop);
    @(posedge clk);
    pu_ok = pv && !m_full[ps];
    po_ok = qv && !m_empty[qs];
    if (cv) begin m_uf &= ~cu; m_of &= ~co; end
    if (qv && m_empty[qs]) m_uf[qs] = 1'b1;
    if (pv && m_full[ps])  m_of[ps] = 1'b1;
    for (int l = 0; l < 4; l++) begin
      bit pp, oo;
      pp = pu_ok && ps == l;
      oo = po_ok && qs == l;
      if (pp) begin m_mem[l][m_head[l]] = pd; m_head[l] = (m_head[l] + 1) % 16; end
      if (oo) m_tail[l] = (m_tail[l] + 1) % 16;
      if (pp && !oo) begin m_empty[l] = 0; m_full[l] = (m_head[l] == m_tail[l]); end
      else if (oo && !pp) begin m_full[l] = 0; m_empty[l] = (m_tail[l] == m_head[l]); end
    end
    #1;
    check_all(tag);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; push_valid = 0; pop_valid = 0; clr_valid = 0;
    push_seq = 0; pop_seq = 0; push_data = 0; status_seq = 0;
    clr_under_mask = 0; clr_over_mask = 0;
    for (int l = 0; l < 4; l++) begin
      m_head[l] = 0; m_tail[l] = 0; m_empty[l] = 1; m_full[l] = 0;
    end
    m_uf = 0; m_of = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1; check_all("R1 reset");

    // fill lane 0, overflow, drain, underflow
    for (int i = 0; i < 16; i++) cyc(1, 0, 32'h100 + i * 32'h01010101, 0, 0, 0, 0, 0, "R3");
    cyc(1, 0, 32'hdead_beef, 0, 0, 0, 0, 0, "R4");
    for (int i = 0; i < 16; i++) cyc(0, 0, 0, 1, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R6");
    // clear, and set-versus-clear in one cycle
    cyc(0, 0, 0, 0, 0, 1, 4'b0001, 4'b0001, "R7");
    cyc(0, 0, 0, 1, 1, 1, 4'b0010, 4'b0000, "R7");
    cyc(0, 0, 0, 0, 0, 1, 4'b1111, 4'b1111, "R7");
    // wrap on lane 2
    for (int i = 0; i < 10; i++) cyc(1, 2, 32'hA000 + i, 0, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 1, 2, 0, 0, 0, "R10");
    for (int i = 0; i < 16; i++) cyc(1, 2, 32'hB000 + i, 0, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 16; i++) cyc(0, 0, 0, 1, 2, 0, 0, 0, "R10");
    // interleaved lanes
    for (int i = 0; i < 24; i++) cyc(1, i % 4, 32'hC000 + i, 1, (i + 1) % 4, 0, 0, 0, "R8");
    // same-lane push and pop: empty, partial, full
    cyc(0, 0, 0, 0, 0, 1, 4'b1111, 4'b1111, "R9");
    for (int i = 0; i < 16; i++) cyc(0, 0, 0, 1, 3, 0, 0, 0, "R9");
    cyc(1, 3, 32'hE0, 1, 3, 0, 0, 0, "R9");
    for (int i = 0; i < 5; i++) cyc(1, 3, 32'hE1 + i, 1, 3, 0, 0, 0, "R9");
    for (int i = 0; i < 15; i++) cyc(1, 3, 32'hF0 + i, 0, 0, 0, 0, 0, "R9");
    cyc(1, 3, 32'hFF, 1, 3, 0, 0, 0, "R9");
    // random mix over all lanes
    for (int i = 0; i < 3000; i++) begin
      int ps, qs;
      ps = int'($urandom_range(3)); qs = int'($urandom_range(3));
      cyc(bit'($urandom_range(1)), ps, $urandom, bit'($urandom_range(1)), qs,
          ($urandom_range(15) == 0), 4'($urandom), 4'($urandom),
          (ps == qs) ? "R9" : "R8");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule